// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Chain Controller

This block arbitrates interrupt requests from ten peripheral sources for a CPU running in vectored interrupt mode. Each source has its own small state slice, holding a pending flag and an in-service flag. A shared priority aggregator decides four things from those flags: which source may raise the CPU interrupt line, which source an acknowledge promotes into service, which source a return-from-interrupt retires, and what the per-source status vector shows. The status vector feeds a DMA-delay flag. That flag tells a DMA engine to hold off while an enabled interrupt is active in vectored mode.

Priority is fixed by index, and index 0 is the highest. The indices map to sources as follows: 0 line, 1 UART0 receive, 2 UART1 receive, 3 to 6 timer channels 0 to 3, 7 video, 8 UART0 transmit, 9 UART1 transmit. An interrupt that is in service blocks every source of lower priority, so only higher-priority sources can nest. A request edge that arrives while its own source is in service is lost. The status vector shows every in-service source and at most one pending source. The CPU bus cycle and the vector byte are handled elsewhere. The acknowledge and return strobes are single-cycle pulses.

Top module: `irq_daisy_ctrl`

## Requirements
- R1: Source index i maps to status bit i, and lower indices win. Bit 10 of the status vector and of the DMA mask is the NMI position.
- R2: A rising edge on req_i[i] sets that source pending, provided the source is not in service. irq_o goes high after that same clock edge if no higher-priority source is in service.
- R3: req_i[i] is sampled low at a clock edge. At that edge the source's pending and in-service flags both clear, and the source stops contributing to irq_o.
- R4: A request held high while its source is in service does not set the pending flag. After return-from-interrupt the source stays idle until req_i falls and rises again.
- R5: An ack_i pulse moves the highest-priority unblocked pending source from pending to in service. irq_o drops if no other unblocked request remains.
- R6: A pending source below an in-service source neither raises irq_o nor gets acknowledged. A pending source above it does both, which makes nesting possible.
- R7: A reti_i pulse retires only the highest-priority in-service source. Blocked lower pending sources then raise irq_o again.
- R8: One cycle after the flags change, status_o[9:0] shows every in-service source. It also shows a pending source, but only if no lower-index bit is already shown.
- R9: status_o[10] takes the value of nmi_i with one register stage of delay.
- R10: dma_delay_o is high exactly when im2_mode_i is high and status_o AND dma_mask_i is nonzero.
- R11: A synchronous rst clears every flag, irq_o, status_o and dma_delay_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 10 | Per-source request levels, index 0 highest priority |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| reti_i | input | 1 | Return-from-interrupt pulse |
| nmi_i | input | 1 | NMI status bit copied into status bit 10 |
| im2_mode_i | input | 1 | Vectored mode enable for the DMA-delay flag |
| dma_mask_i | input | 11 | DMA interrupt enable mask, same layout as status_o |
| irq_o | output | 1 | CPU interrupt line |
| status_o | output | 11 | Registered per-source status vector |
| dma_delay_o | output | 1 | DMA hold-off flag |

## Verification
The assertions check the following on every cycle. A low request clears both of its flags. No source becomes pending while it is in service. The acknowledge and return selections are each at most one-hot. Every in-service source appears in the next status vector, and that vector shows no more than one source that is only pending. The NMI bit tracks its input with one cycle of delay. Only the directed scenarios show the order of events across several cycles: the priority picked among simultaneous requests, nesting and unwinding through return-from-interrupt, a lost request edge staying lost, and the masking of the DMA-delay flag.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned SRC_COUNT = 10;
  localparam int unsigned STAT_W    = SRC_COUNT + 1;
  localparam int unsigned NMI_POS   = SRC_COUNT;

  typedef struct packed {
    logic pend;
    logic insvc;
  } slot_flags_t;
endpackage

// File: rtl/irqd_slot.sv
module irqd_slot (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_i,
  input  logic                  grant_i,
  input  logic                  retire_i,
  output irqd_pkg::slot_flags_t flags_o
);
  logic                  req_q;
  irqd_pkg::slot_flags_t st;
  logic                  rise;

  assign rise    = req_i & ~req_q;
  assign flags_o = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      st.pend  <= 1'b0;
      st.insvc <= 1'b0;
    end else begin
      req_q <= req_i;
      if (!req_i) begin
        st.pend  <= 1'b0;
        st.insvc <= 1'b0;
      end else if (grant_i) begin
        st.pend  <= 1'b0;
        st.insvc <= 1'b1;
      end else begin
        if (retire_i) st.insvc <= 1'b0;
        if (rise && !st.insvc) st.pend <= 1'b1;
      end
    end
  end

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!st.pend && !st.insvc)); // R3
  AST_SVC_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (st.insvc && !retire_i) |=> !st.pend); // R4
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] insvc_i,
  input  logic         ack_i,
  input  logic         reti_i,
  output logic [N-1:0] grant_o,
  output logic [N-1:0] retire_o,
  output logic [N-1:0] stat_next_o,
  output logic         irq_o
);
  always_comb begin
    logic blocked, granted, retired, shown, live;
    blocked     = 1'b0;
    granted     = 1'b0;
    retired     = 1'b0;
    shown       = 1'b0;
    grant_o     = '0;
    retire_o    = '0;
    stat_next_o = '0;
    irq_o       = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      live  = pend_i[i] & ~blocked;
      irq_o = irq_o | live;
      if (ack_i && live && !granted) begin
        grant_o[i] = 1'b1;
        granted    = 1'b1;
      end
      if (reti_i && insvc_i[i] && !retired) begin
        retire_o[i] = 1'b1;
        retired     = 1'b1;
      end
      stat_next_o[i] = insvc_i[i] | (pend_i[i] & ~shown);
      shown          = shown | stat_next_o[i];
      blocked        = blocked | insvc_i[i];
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o)); // R5
  AST_RETIRE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(retire_o)); // R7
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
    ((grant_o & ~pend_i) == '0)); // R6
endmodule

// File: rtl/irqd_status.sv
module irqd_status #(
  parameter int unsigned N = 10,
  localparam int unsigned W = N + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stat_next_i,
  input  logic [N-1:0] insvc_i,
  input  logic         nmi_i,
  input  logic         mode_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] status_o,
  output logic         dma_delay_o
);
  always_ff @(posedge clk) begin
    if (rst) status_o <= '0;
    else     status_o <= {nmi_i, stat_next_i};
  end

  assign dma_delay_o = mode_i & (|(status_o & mask_i));

  AST_SVC_SHOWN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_o[N-1:0] & $past(insvc_i)) == $past(insvc_i))); // R8
  AST_ONE_PEND_SHOWN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $onehot0(status_o[N-1:0] & ~$past(insvc_i))); // R8
  AST_NMI_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_o[N] == $past(nmi_i))); // R9
endmodule

// File: rtl/irq_daisy_ctrl.sv
module irq_daisy_ctrl #(
  parameter int unsigned NUM_SRC = 10,
  localparam int unsigned SW = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               ack_i,
  input  logic               reti_i,
  input  logic               nmi_i,
  input  logic               im2_mode_i,
  input  logic [SW-1:0]      dma_mask_i,
  output logic               irq_o,
  output logic [SW-1:0]      status_o,
  output logic               dma_delay_o
);
  logic [NUM_SRC-1:0] pend, insvc, grant, retire, stat_next;

  for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_slot
    irqd_pkg::slot_flags_t fl;
    irqd_slot u_slot (
      .clk     (clk),
      .rst     (rst),
      .req_i   (req_i[g]),
      .grant_i (grant[g]),
      .retire_i(retire[g]),
      .flags_o (fl)
    );
    assign pend[g]  = fl.pend;
    assign insvc[g] = fl.insvc;
  end

  irqd_arbiter #(.N(NUM_SRC)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .pend_i     (pend),
    .insvc_i    (insvc),
    .ack_i      (ack_i),
    .reti_i     (reti_i),
    .grant_o    (grant),
    .retire_o   (retire),
    .stat_next_o(stat_next),
    .irq_o      (irq_o)
  );

  irqd_status #(.N(NUM_SRC)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .stat_next_i(stat_next),
    .insvc_i    (insvc),
    .nmi_i      (nmi_i),
    .mode_i     (im2_mode_i),
    .mask_i     (dma_mask_i),
    .status_o   (status_o),
    .dma_delay_o(dma_delay_o)
  );

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (pend != '0)); // R2
endmodule

// File: tb/tb_irq_daisy_ctrl.sv
module tb_irq_daisy_ctrl;
  localparam int N = 10;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0;
  logic ack = 1'b0, reti = 1'b0, nmi = 1'b0, mode = 1'b0;
  logic [N:0] mask = '0;
  logic irq, dly;
  logic [N:0] stat;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_daisy_ctrl dut (
    .clk(clk), .rst(rst), .req_i(req), .ack_i(ack), .reti_i(reti),
    .nmi_i(nmi), .im2_mode_i(mode), .dma_mask_i(mask),
    .irq_o(irq), .status_o(stat), .dma_delay_o(dly)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; step(1); reti = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 irq after reset", irq, 0);
    chk("R11 status after reset", stat, 0);
    chk("R11 dma after reset", dly, 0);
  endtask

  task automatic t_single();
    req[5] = 1'b1; step(1);
    chk("R2 irq after edge", irq, 1);
    step(1);
    chk("R8 pending shown", stat, 11'h020);
    pulse_ack();
    chk("R5 irq drops after ack", irq, 0);
    step(1);
    chk("R8 in-service shown", stat, 11'h020);
    mask = 11'h020; mode = 1'b1; #1;
    chk("R10 dma on", dly, 1);
    mode = 1'b0; #1;
    chk("R10 dma off without mode", dly, 0);
    mode = 1'b1; mask = 11'h010; #1;
    chk("R10 dma off when masked", dly, 0);
    mode = 1'b0; mask = '0;
    pulse_reti(); step(1);
    chk("R4 held request not re-pended irq", irq, 0);
    chk("R4 held request not re-pended status", stat, 0);
    req[5] = 1'b0; step(1);
    req[5] = 1'b1; step(1);
    chk("R4 fresh edge pends again", irq, 1);
    req[5] = 1'b0; step(2);
  endtask

  task automatic t_priority();
    req[7] = 1'b1; req[2] = 1'b1; step(2);
    chk("R1 highest of two shown", stat, 11'h004);
    pulse_ack(); step(1);
    chk("R6 lower blocked irq", irq, 0);
    chk("R5 source 2 in service", stat, 11'h004);
    req[0] = 1'b1; step(1);
    chk("R6 higher nests irq", irq, 1);
    step(1);
    chk("R8 nested pending shown", stat, 11'h005);
    pulse_ack(); step(1);
    chk("R6 both in service", stat, 11'h005);
    pulse_reti(); step(1);
    chk("R7 only top retired", stat, 11'h004);
    chk("R7 still blocked", irq, 0);
    pulse_reti();
    chk("R7 blocked source raises irq", irq, 1);
    step(1);
    chk("R8 unblocked pending shown", stat, 11'h080);
    pulse_ack(); step(1);
    chk("R5 source 7 in service", stat, 11'h080);
    req = '0; step(1);
    chk("R3 drop clears irq", irq, 0);
    step(1);
    chk("R3 drop clears status", stat, 0);
  endtask

  task automatic t_drop();
    req[4] = 1'b1; step(1);
    pulse_ack();
    req[4] = 1'b0; step(2);
    chk("R3 in-service cleared by drop", stat, 0);
    req[4] = 1'b1; step(1);
    chk("R3 new request after drop", irq, 1);
    req[4] = 1'b0; step(2);
  endtask

  task automatic t_nmi();
    nmi = 1'b1; step(1);
    chk("R9 nmi bit", stat, 11'h400);
    mask = 11'h400; mode = 1'b1; #1;
    chk("R10 dma from nmi bit", dly, 1);
    nmi = 1'b0; step(1);
    chk("R9 nmi bit clears", stat, 0);
    chk("R10 dma follows", dly, 0);
    mask = '0; mode = 1'b0;
  endtask

  task automatic t_reset_mid();
    req[1] = 1'b1; nmi = 1'b1; step(1);
    pulse_ack(); step(1);
    rst = 1'b1; nmi = 1'b0; step(1);
    chk("R11 status cleared", stat, 0);
    chk("R11 irq cleared", irq, 0);
    rst = 1'b0; req[1] = 1'b0; step(2);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_single();
    t_priority();
    t_drop();
    t_nmi();
    t_reset_mid();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule